// File: doc/BRIEF.md
# Oversampling Sample Averager

This block follows a 12-bit successive-approximation converter and turns a run of its conversions into one averaged result. A start pulse opens a run and fixes the oversampling ratio, a power of two from 2 to 4096 chosen by a 4-bit code. Each sample that arrives with its valid strobe while the run is open is added to a wide running sum. When the last sample of the run has been added, the sum is scaled down and registered as the result.

The result widens with the ratio up to 16x, from 13 bits at 2x to 16 bits at 16x, with no scaling applied. Above 16x the width stays at 16 bits, and the sum is shifted right by one more bit for each doubling of the ratio. The result is clamped to the 16-bit range. A one-cycle strobe marks each new result, and the value is held until the next one. A new start pulse at any time abandons the current run and begins a fresh one.

Top module: `ovs_average`

## Requirements
- R1: While reset is asserted and after it is released, `resultValid` is 0 and `resultData` is 0 until the first run completes.
- R2: Ratio code k in 0..11 selects 2^(k+1) samples per run. Codes 12 to 15 select 4096 samples. The code is sampled only on the cycle `start` is high.
- R3: For 2x, 4x, 8x and 16x (codes 0 to 3), `resultData` equals the exact sum of the run's samples.
- R4: For 32x through 4096x (codes 4 to 11), `resultData` equals the sum shifted right by log2(ratio) minus 4, that is by 1 to 8 bits, with the low bits truncated.
- R5: `resultValid` is high for exactly one cycle. It rises on the clock edge at which the run's final sample is accepted, and a new result appears only after a sample was accepted.
- R6: `resultData` changes only on the edge that raises `resultValid`, and otherwise holds its value.
- R7: A `start` pulse during a run discards the partial sum and the count and begins a new run. A sample presented on the same cycle as `start` is not counted, and no result is raised on the cycle after a `start`.
- R8: Samples presented while no run is open are ignored. This covers samples before any start and samples after a run completes. A change of the ratio code during a run has no effect.
- R9: The result never exceeds 0xFFFF. Full-scale input (4095 on every sample) gives 65520 at every ratio from 16x upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new run, clears the sum and the count |
| ratioSel | input | 4 | Oversampling ratio code, sampled with `start` |
| sampleValid | input | 1 | Marks `sampleData` as a new conversion |
| sampleData | input | 12 | Unsigned conversion result |
| resultData | output | 16 | Scaled sum of the last completed run |
| resultValid | output | 1 | One-cycle strobe for a new `resultData` |

## Verification
The assertions check the timing on every cycle. They confirm that the result strobe lasts one cycle, that it never follows a start directly, that it always follows an accepted sample, and that the result holds steady between strobes. The arithmetic cannot be seen from the ports alone. This covers the per-ratio sample count, the shift amount, code clamping, partial-sum discard and idle samples being ignored. The bench shows these by comparing against its own behavioural model, in scenarios that cover each ratio class, gapped input, restarts and full-scale data.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int SAMPLE_W  = 12;
  localparam int MAX_LOG2  = 12;
  localparam int FLAT_LOG2 = 4;
  localparam int OUT_W     = 16;
  localparam int CODE_W    = 4;
  localparam int SHIFT_W   = 4;
  localparam int ACC_W     = SAMPLE_W + MAX_LOG2;

  typedef struct packed {
    logic               clr;
    logic               add;
    logic               load;
    logic [SHIFT_W-1:0] shift;
  } ovs_ctrl_t;
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
  import ovs_pkg::*;
#(
  parameter int MaxLog2  = MAX_LOG2,
  parameter int FlatLog2 = FLAT_LOG2,
  parameter int CodeW    = CODE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CodeW-1:0] ratioSel,
  input  logic             sampleValid,
  output ovs_ctrl_t        ctrl
);
  localparam int CntW = MaxLog2 + 1;
  localparam int LgW  = $clog2(MaxLog2 + 1);

  logic            active;
  logic [CntW-1:0] sampleCnt;
  logic [LgW-1:0]  runLog2;
  logic [LgW-1:0]  selLog2;
  logic [CntW-1:0] lastIdx;
  logic            isLast;

  // Codes above the largest ratio are clamped to it.
  always_comb begin
    if (int'(ratioSel) >= MaxLog2 - 1) selLog2 = LgW'(MaxLog2);
    else                               selLog2 = LgW'(ratioSel) + LgW'(1);
  end

  assign lastIdx = (CntW'(1) << runLog2) - CntW'(1);
  assign isLast  = (sampleCnt == lastIdx);

  always_comb begin
    ctrl.clr   = start;
    ctrl.add   = active && sampleValid && !start;
    ctrl.load  = ctrl.add && isLast;
    if (int'(runLog2) > FlatLog2) ctrl.shift = SHIFT_W'(int'(runLog2) - FlatLog2);
    else                          ctrl.shift = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      sampleCnt <= '0;
      runLog2   <= LgW'(1);
    end else if (start) begin
      active    <= 1'b1;
      sampleCnt <= '0;
      runLog2   <= selLog2;
    end else if (ctrl.add) begin
      sampleCnt <= sampleCnt + CntW'(1);
      if (isLast) active <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_dpath.sv
module ovs_dpath
  import ovs_pkg::*;
#(
  parameter int SampleW = SAMPLE_W,
  parameter int AccW    = ACC_W,
  parameter int OutW    = OUT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ovs_ctrl_t          ctrl,
  input  logic [SampleW-1:0] sampleData,
  output logic [OutW-1:0]    resultData,
  output logic               resultValid
);
  logic [AccW-1:0] acc;
  logic [AccW-1:0] nextSum;
  logic [AccW-1:0] scaled;
  logic [OutW-1:0] clamped;

  assign nextSum = acc + AccW'(sampleData);
  assign scaled  = nextSum >> ctrl.shift;

  generate
    if (AccW > OutW) begin : g_sat
      assign clamped = (|scaled[AccW-1:OutW]) ? {OutW{1'b1}} : scaled[OutW-1:0];
    end else begin : g_nosat
      assign clamped = OutW'(scaled);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctrl.load;
      if (ctrl.clr)      acc <= '0;
      else if (ctrl.add) acc <= nextSum;
      if (ctrl.load) resultData <= clamped;
    end
  end
endmodule

// File: rtl/ovs_average.sv
module ovs_average
  import ovs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CODE_W-1:0]   ratioSel,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [OUT_W-1:0]    resultData,
  output logic                resultValid
);
  ovs_ctrl_t ctrl;

  ovs_ctrl #(.MaxLog2(MAX_LOG2), .FlatLog2(FLAT_LOG2), .CodeW(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ratioSel(ratioSel),
    .sampleValid(sampleValid), .ctrl(ctrl)
  );

  ovs_dpath #(.SampleW(SAMPLE_W), .AccW(ACC_W), .OutW(OUT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleData(sampleData),
    .resultData(resultData), .resultValid(resultValid)
  );
endmodule

// File: rtl/ovs_average_chk.sv
module ovs_average_chk
  import ovs_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             sampleValid,
  input logic [OUT_W-1:0] resultData,
  input logic             resultValid
);
  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5
  needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $past(sampleValid));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultData));

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !resultValid);
endmodule

bind ovs_average ovs_average_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
  .resultData(resultData), .resultValid(resultValid)
);

// File: tb/ovs_average_bench.sv
module ovs_average_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  ratioSel = '0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic [15:0] resultData;
  logic        resultValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // behavioural model state
  bit     mActive = 0;
  int     mCnt = 0, mN = 2, mLog = 1;
  longint mSum = 0;
  bit     expV = 0;
  longint expD = 0;

  always #5 clk = ~clk;

  ovs_average u_ovs_average (
    .clk(clk), .rstN(rstN), .start(start), .ratioSel(ratioSel),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .resultData(resultData), .resultValid(resultValid)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mCnt = 0; mSum = 0; expV = 0; expD = 0;
    end else begin
      expV = 0;
      if (start) begin
        mActive = 1; mCnt = 0; mSum = 0;
        mLog = (ratioSel >= 11) ? 12 : int'(ratioSel) + 1;
        mN = 1 << mLog;
      end else if (mActive && sampleValid) begin
        mSum += sampleData;
        mCnt++;
        if (mCnt == mN) begin
          longint r;
          mActive = 0;
          r = mSum >> ((mLog > 4) ? mLog - 4 : 0);
          if (r > 65535) r = 65535;
          expD = r; expV = 1;
        end
      end
    end
  end

  // every-cycle model comparison: R5 R6
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R5 model strobe", resultValid, expV);
      check("R6 model data", resultData, expD);
    end
  end

  task automatic doStart(input int code);
    @(negedge clk);
    start = 1; ratioSel = 4'(code); sampleValid = 0;
    @(negedge clk);
    start = 0;
  endtask

  function automatic int val(input int kind, input int i);
    case (kind)
      0: return (i * 37 + 5) % 4096;
      1: return 4095;
      default: return (i * 911 + 3) % 4096;
    endcase
  endfunction

  // Runs n samples; sum returned. Leaves the bench on the negedge after the last sample.
  task automatic feed(input int n, input int kind, input int gap, output longint s);
    s = 0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) begin
        @(negedge clk);
        sampleValid = 0;
        for (int g = 0; g < gap; g++) @(negedge clk);
      end
      sampleValid = 1; sampleData = 12'(val(kind, i));
      s += val(kind, i);
    end
    @(negedge clk);
    sampleValid = 0;
  endtask

  task automatic run(input string req, input int code, input int n, input int kind,
                     input int gap, input int sh);
    longint s, e;
    doStart(code);
    feed(n, kind, gap, s);
    e = s >> sh;
    if (e > 65535) e = 65535;
    check({req, " strobe"}, resultValid, 1);
    check({req, " value"}, resultData, e);
    @(negedge clk);
    check("R5 strobe drop", resultValid, 0);
    check("R6 hold", resultData, e);
  endtask

  initial begin
    longint s;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", resultValid, 0);
    check("R1 data in reset", resultData, 0);
    rstN = 1;
    // R8 samples before any start
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sampleValid = 1; sampleData = 12'd999;
    end
    @(negedge clk); sampleValid = 0;
    check("R1 valid after reset", resultValid, 0);
    check("R8 idle data", resultData, 0);

    // R3 flat ratios
    run("R3 2x", 0, 2, 0, 0, 0);
    run("R3 8x gapped", 2, 8, 2, 2, 0);
    run("R3 R9 16x full", 3, 16, 1, 0, 0);
    // R4 shifted ratios
    run("R4 32x", 4, 32, 0, 1, 1);
    run("R4 256x", 7, 256, 2, 0, 4);
    run("R4 R9 4096x full", 11, 4096, 1, 0, 8);
    // R2 clamped code
    run("R2 code15", 15, 4096, 0, 0, 8);
    run("R2 code1 4x", 1, 4, 2, 0, 0);

    // R7 restart mid-run with coincident sample
    doStart(4);
    for (int i = 0; i < 10; i++) begin
      sampleValid = 1; sampleData = 12'd4000; @(negedge clk);
    end
    start = 1; ratioSel = 0; sampleValid = 1; sampleData = 12'd2000;
    @(negedge clk);
    start = 0;
    check("R7 no strobe after start", resultValid, 0);
    sampleValid = 1; sampleData = 12'd1; @(negedge clk);
    sampleData = 12'd2; @(negedge clk);
    sampleValid = 0;
    check("R7 restart strobe", resultValid, 1);
    check("R7 restart value", resultData, 3);

    // R8 ratio change mid-run ignored, idle samples after done ignored
    doStart(1);
    sampleValid = 1; sampleData = 12'd10; @(negedge clk);
    ratioSel = 4'd9;
    sampleData = 12'd20; @(negedge clk);
    sampleData = 12'd30; @(negedge clk);
    sampleData = 12'd40; @(negedge clk);
    sampleValid = 0;
    check("R8 ratio latched strobe", resultValid, 1);
    check("R8 ratio latched value", resultData, 100);
    for (int i = 0; i < 6; i++) begin
      sampleValid = 1; sampleData = 12'd4095; @(negedge clk);
      check("R8 post-run strobe", resultValid, 0);
    end
    sampleValid = 0;
    check("R8 post-run data", resultData, 100);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule